// File: doc/BRIEF.md
# Stripe Ping-Pong Coefficient Buffer

This block decouples a wavelet-transform producer from a block-coder consumer by handing detail-subband coefficients across one stripe at a time. It keeps two banks, each made of three stripe memories (one per detail subband: HL, LH, HH), and a single stripe memory for the low-pass (LL) band. The producer fills one bank while the consumer drains the other. The two banks exchange roles at the boundary between pipeline stages.

A stripe is four rows high and `COLS` columns wide. The producer writes with a row-major address `row*COLS + col`. The consumer does not supply addresses. It names a subband, and the block returns that subband's coefficients in stripe-scan order: column by column from left to right, and top to bottom inside each column. A stage on detail bands therefore carries `3*4*COLS` coefficients, and a stage that also drains LL carries `4*4*COLS`.

Each side ends its stage with a one-cycle done pulse. The exchange happens only when both sides have finished. Whichever side finishes first waits until the other finishes. The single LL memory belongs to only one side at a time.

Top module: `stripe_pingpong_buf`

## Requirements
- R1: While reset is held and after it is released, `rd_valid` is 0 and `prod_ready` is 1.
- R2: Before the first bank exchange the consumer has no completed bank, so a read request returns `rd_valid` = 0.
- R3: The banks exchange only after both the producer (`wr_done`) and the consumer (`rd_done`) have signalled the end of their stage. `prod_ready` is 0 from the cycle after `wr_done` until the exchange, and is 1 again in the cycle after it. Immediately after reset the consumer side counts as finished.
- R4: A write presented while `prod_ready` is 0 is ignored. The data the consumer later reads is unchanged by it.
- R5: A read request is answered in the next cycle. The k-th accepted request for a subband in a stage returns the coefficient written at address `(k mod 4)*COLS + k/4`.
- R6: Every coefficient of a subband is delivered exactly once per stage. After `4*COLS` accepted reads of that subband, further requests return `rd_valid` = 0 until the next exchange.
- R7: Data the producer writes during one stage is what the consumer reads during the next stage. Writes made during the consumer's stage do not disturb the bank being read.
- R8: Subband codes are LL=0, HL=1, LH=2, HH=3. The LL memory passes to the consumer at an exchange only if the producer wrote LL during the stage that just ended. It returns to the producer at the following exchange. Producer LL writes while the consumer holds LL are ignored. Consumer LL reads while the producer holds it return `rd_valid` = 0.
- R9: After the consumer pulses `rd_done`, its read requests return `rd_valid` = 0 until the next exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Producer write strobe |
| wr_band | input | 2 | Producer subband code (LL=0, HL=1, LH=2, HH=3) |
| wr_addr | input | ADDR_W | Row-major position within the stripe, row*COLS+col |
| wr_data | input | DATA_W | Coefficient to store |
| wr_done | input | 1 | Producer end-of-stage pulse |
| prod_ready | output | 1 | Producer may write; 0 while it waits for the exchange |
| rd_req | input | 1 | Consumer request for the next coefficient of `rd_band` |
| rd_band | input | 2 | Consumer subband code |
| rd_done | input | 1 | Consumer end-of-stage pulse |
| rd_data | output | DATA_W | Coefficient returned one cycle after an accepted request |
| rd_valid | output | 1 | `rd_data` holds a delivered coefficient |

## Verification
The bench builds the block with `COLS` = 4, so each stripe memory holds 16 entries. With that size, complete stages for all four subbands run in a few hundred cycles, and every scan wrap from the bottom of one column to the top of the next gets checked against a fixed table of scan addresses. The short stages also leave room to exercise a producer stall, a consumer that finishes early, blocked writes, and the LL memory handed to the consumer and back again. The default width of 64 columns is only elaborated.

// File: rtl/spb_pkg.sv
package spb_pkg;

    typedef enum logic [1:0] {
        BAND_LL = 2'd0,
        BAND_HL = 2'd1,
        BAND_LH = 2'd2,
        BAND_HH = 2'd3
    } band_e;

    localparam int unsigned NUM_BANKS   = 2;
    localparam int unsigned NUM_DETAIL  = 3;
    localparam int unsigned NUM_BANDS   = 4;
    localparam int unsigned STRIPE_ROWS = 4;

    typedef struct packed {
        logic wbank;      // bank the producer fills
        logic prod_fin;   // producer finished its stage
        logic cons_fin;   // consumer finished its stage
        logic loaded;     // consumer bank holds completed data
        logic ll_seen;    // producer wrote LL during this stage
        logic ll_cons;    // LL memory belongs to the consumer
    } ctl_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] band;
        logic       bank;
    } rd_tag_t;

endpackage

// File: rtl/spb_stripe_mem.sv
module spb_stripe_mem #(
    parameter int unsigned DATA_W = 11,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/spb_scan_gen.sv
module spb_scan_gen #(
    parameter int unsigned COLS = 64,
    localparam int unsigned DEPTH  = spb_pkg::STRIPE_ROWS * COLS,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              exhausted
);

    typedef struct packed {
        logic [1:0]       row;
        logic [COL_W-1:0] col;
        logic             exh;
    } scan_t;

    scan_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (step && !s_q.exh) begin
            if (s_q.row == 2'(spb_pkg::STRIPE_ROWS - 1)) begin
                s_d.row = '0;
                if (s_q.col == COL_W'(COLS - 1)) begin
                    s_d.exh = 1'b1;
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end else begin
                s_d.row = s_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr      = ADDR_W'(s_q.row) * ADDR_W'(COLS) + ADDR_W'(s_q.col);
    assign exhausted = s_q.exh;

endmodule

// File: rtl/spb_swap_ctrl.sv
module spb_swap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_done,
    input  logic rd_done,
    input  logic ll_wr_fire,
    output logic wbank,
    output logic prod_wait,
    output logic cons_wait,
    output logic loaded,
    output logic ll_cons,
    output logic swap
);
    import spb_pkg::*;

    ctl_t c_q, c_d;
    logic swap_now;

    assign swap_now = c_q.prod_fin && c_q.cons_fin;

    always_comb begin
        c_d = c_q;
        if (swap_now) begin
            c_d.wbank    = ~c_q.wbank;
            c_d.prod_fin = 1'b0;
            c_d.cons_fin = 1'b0;
            c_d.loaded   = 1'b1;
            c_d.ll_seen  = 1'b0;
            // LL goes to the consumer only if freshly written, otherwise it returns
            c_d.ll_cons  = c_q.ll_cons ? 1'b0 : c_q.ll_seen;
        end else begin
            c_d.prod_fin = c_q.prod_fin | wr_done;
            c_d.cons_fin = c_q.cons_fin | rd_done;
            c_d.ll_seen  = c_q.ll_seen | ll_wr_fire;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q          <= '0;
            c_q.cons_fin <= 1'b1;  // no bank loaded yet: consumer has nothing to do
        end else begin
            c_q <= c_d;
        end
    end

    assign wbank     = c_q.wbank;
    assign prod_wait = c_q.prod_fin;
    assign cons_wait = c_q.cons_fin;
    assign loaded    = c_q.loaded;
    assign ll_cons   = c_q.ll_cons;
    assign swap      = swap_now;

endmodule

// File: rtl/stripe_pingpong_buf.sv
module stripe_pingpong_buf #(
    parameter int unsigned DATA_W = 11,
    parameter int unsigned COLS   = 64,
    localparam int unsigned DEPTH  = spb_pkg::STRIPE_ROWS * COLS,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_band,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_done,
    output logic              prod_ready,
    input  logic              rd_req,
    input  logic [1:0]        rd_band,
    input  logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    import spb_pkg::*;

    logic wbank, prod_wait, cons_wait, loaded, ll_cons, swap;
    logic wr_fire, rd_fire, ll_wr_fire, ll_rd_fire;

    logic [ADDR_W-1:0] scan_addr [NUM_BANDS];
    logic              scan_exh  [NUM_BANDS];
    logic [DATA_W-1:0] det_rdata [NUM_BANKS*NUM_DETAIL];
    logic [DATA_W-1:0] ll_rdata;
    logic [ADDR_W-1:0] rd_addr;

    rd_tag_t t_q, t_d;

    // ---------------- stage control ----------------
    spb_swap_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_done    (wr_done),
        .rd_done    (rd_done),
        .ll_wr_fire (ll_wr_fire),
        .wbank      (wbank),
        .prod_wait  (prod_wait),
        .cons_wait  (cons_wait),
        .loaded     (loaded),
        .ll_cons    (ll_cons),
        .swap       (swap)
    );

    assign prod_ready = !prod_wait;
    assign wr_fire    = wr_en && !prod_wait && !(wr_band == BAND_LL && ll_cons);
    assign ll_wr_fire = wr_fire && (wr_band == BAND_LL);
    assign rd_fire    = rd_req && loaded && !cons_wait && !scan_exh[rd_band]
                        && !(rd_band == BAND_LL && !ll_cons);
    assign ll_rd_fire = rd_fire && (rd_band == BAND_LL);
    assign rd_addr    = scan_addr[rd_band];

    // ---------------- per-band scan counters ----------------
    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_scan
        spb_scan_gen #(.COLS(COLS)) u_scan (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (swap),
            .step      (rd_fire && (rd_band == 2'(g))),
            .addr      (scan_addr[g]),
            .exhausted (scan_exh[g])
        );
    end

    // ---------------- detail stripe memories, two banks ----------------
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar d = 0; d < NUM_DETAIL; d++) begin : g_band
            localparam logic [1:0] BD = 2'(d + 1);
            spb_stripe_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
                .clk   (clk),
                .we    (wr_fire && (wr_band == BD) && (wbank == 1'(b))),
                .waddr (wr_addr),
                .wdata (wr_data),
                .re    (rd_fire && (rd_band == BD) && (wbank != 1'(b))),
                .raddr (rd_addr),
                .rdata (det_rdata[b*NUM_DETAIL + d])
            );
        end
    end

    // ---------------- single LL stripe memory ----------------
    spb_stripe_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ll_mem (
        .clk   (clk),
        .we    (ll_wr_fire),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (ll_rd_fire),
        .raddr (rd_addr),
        .rdata (ll_rdata)
    );

    // ---------------- read tag and output select ----------------
    always_comb begin
        t_d       = t_q;
        t_d.valid = rd_fire;
        if (rd_fire) begin
            t_d.band = rd_band;
            t_d.bank = ~wbank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    always_comb begin
        if (t_q.band == BAND_LL) begin
            rd_data = ll_rdata;
        end else begin
            rd_data = det_rdata[int'(t_q.bank) * NUM_DETAIL + int'(t_q.band) - 1];
        end
    end

    assign rd_valid = t_q.valid;

endmodule

// File: rtl/spb_checker.sv
module spb_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_fire,
    input logic wr_done,
    input logic prod_ready,
    input logic rd_req,
    input logic rd_valid,
    input logic swap,
    input logic loaded,
    input logic ll_wr_fire,
    input logic ll_rd_fire
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!rd_valid && prod_ready)); // R1
    AST_NO_READ_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> loaded); // R2
    AST_STALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) (wr_done && prod_ready) |=> !prod_ready); // R3
    AST_SWAP_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n) swap |-> !prod_ready); // R3
    AST_STALLED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !prod_ready) |-> !wr_fire); // R4
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(rd_req)); // R5
    AST_LL_SINGLE_SIDE: assert property (@(posedge clk) disable iff (!rst_n) !(ll_wr_fire && ll_rd_fire)); // R8

endmodule

bind stripe_pingpong_buf spb_checker i_spb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_fire    (wr_fire),
    .wr_done    (wr_done),
    .prod_ready (prod_ready),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .swap       (swap),
    .loaded     (loaded),
    .ll_wr_fire (ll_wr_fire),
    .ll_rd_fire (ll_rd_fire)
);

// File: tb/test_stripe_pingpong_buf.sv
module test_stripe_pingpong_buf;

    localparam int COLS   = 4;
    localparam int DEPTH  = 4 * COLS;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int DATA_W = 11;

    // expected stripe-scan addresses for COLS=4: (k%4)*4 + k/4
    localparam int SCAN_TBL [DEPTH] = '{0, 4, 8, 12, 1, 5, 9, 13, 2, 6, 10, 14, 3, 7, 11, 15};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_band = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_done = 1'b0;
    logic              prod_ready;
    logic              rd_req = 1'b0;
    logic [1:0]        rd_band = '0;
    logic              rd_done = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stripe_pingpong_buf #(.DATA_W(DATA_W), .COLS(COLS)) i_stripe_pingpong_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_band(wr_band), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_done(wr_done), .prod_ready(prod_ready),
        .rd_req(rd_req), .rd_band(rd_band), .rd_done(rd_done),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [DATA_W-1:0] pat(int s, int band, int addr);
        return DATA_W'((s << 6) | (band << 4) | addr);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_one(int band, int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_band = 2'(band); wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill(int s, int band);
        for (int a = 0; a < DEPTH; a++) write_one(band, a, pat(s, band, a));
    endtask

    task automatic read_one(int band, output logic v, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_req = 1'b1; rd_band = 2'(band);
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic drain(int s, int band, string req);
        logic v;
        logic [DATA_W-1:0] d;
        for (int k = 0; k < DEPTH; k++) begin
            read_one(band, v, d);
            check(req, int'(v), 1);
            check(req, int'(d), int'(pat(s, band, SCAN_TBL[k])));
        end
    endtask

    task automatic pulse_wr_done();
        @(negedge clk); wr_done = 1'b1;
        @(negedge clk); wr_done = 1'b0;
    endtask

    task automatic pulse_rd_done();
        @(negedge clk); rd_done = 1'b1;
        @(negedge clk); rd_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic v;
        logic [DATA_W-1:0] d;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(rd_valid), 0);
        check("R1 ready in reset", int'(prod_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(rd_valid), 0);
        check("R1 ready after reset", int'(prod_ready), 1);

        // R2: nothing completed yet
        read_one(1, v, d);
        check("R2 read before first exchange", int'(v), 0);

        // stage 1: producer fills all bands
        for (int b = 0; b < 4; b++) fill(1, b);
        pulse_wr_done();
        check("R3 stall after done", int'(prod_ready), 0);
        @(negedge clk);
        check("R3 ready after exchange", int'(prod_ready), 1);

        // stage 2: producer writes detail bands, tries LL (held by consumer)
        for (int b = 1; b < 4; b++) fill(2, b);
        fill(2, 0);
        for (int b = 0; b < 4; b++) drain(1, b, "R5 R7 R8 scan order");
        for (int b = 0; b < 4; b++) begin
            read_one(b, v, d);
            check("R6 extra read after full stripe", int'(v), 0);
        end
        pulse_wr_done();
        repeat (5) @(negedge clk);
        check("R3 producer stalls until consumer done", int'(prod_ready), 0);
        write_one(1, 0, 11'h7FF);
        pulse_rd_done();
        @(negedge clk);
        check("R3 ready after both done", int'(prod_ready), 1);

        // stage 3
        read_one(0, v, d);
        check("R8 LL not handed over without fresh write", int'(v), 0);
        drain(2, 1, "R4 R7 data intact after stalled write");
        drain(2, 2, "R7 LH stage 2");
        fill(3, 0);
        fill(3, 1);
        pulse_rd_done();
        read_one(3, v, d);
        check("R9 read after consumer done", int'(v), 0);
        pulse_wr_done();
        @(negedge clk);
        check("R3 ready after exchange 3", int'(prod_ready), 1);

        // stage 4: LL handed to consumer
        drain(3, 0, "R8 LL handed over");
        drain(3, 1, "R7 HL stage 3");
        write_one(0, 0, 11'h7FF);
        pulse_wr_done();
        pulse_rd_done();
        @(negedge clk);
        // stage 5: LL back with producer; consumer LL read blocked
        read_one(0, v, d);
        check("R8 LL returned to producer", int'(v), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule